// File: doc/BRIEF.md
# Five-Source Prioritized Interrupt Controller

This block sits beside a small 8-bit processor core and decides which of five interrupt sources is handed to it. The sources are a non-maskable trap, three automatically vectored restart lines and one general request line. The trap and the highest restart line are caught on rising edges and held in latches. The two lower restart lines and the general request are level sensitive. The block combines these inputs with a three-bit mask and a global enable and resolves priority. While a winner exists, it raises a request toward the core and presents that winner's vector address.

The core changes the controller's settings through a mask-write byte. Bit qualifiers select which of the byte's fields take effect, and the same byte drives a one-bit serial output. The core reads a status byte that reports the masks, the global enable, the three restart pending flags and a serial input pin. The global enable is set and cleared by enable/disable pulses from the core. Accepting any interrupt clears it.

A three-state machine runs the handshake with the core. In `ST_IDLE` the block has no request. The transition IDLE→WAIT happens when any source is eligible. In `ST_WAIT`, `irq_out` is high and `vec_out` shows the current winner. The transition WAIT→IDLE happens if every eligible source goes away first. The transition WAIT→GRANT happens when the core pulses `core_take` while a winner exists. That edge is the acceptance: it clears the global enable and, for the trap or the edge-latched restart, that source's latch. `ST_GRANT` lasts one cycle and strobes `inta_out` if the general request won. The transition GRANT→IDLE is unconditional.

Top module: `vintc_top`

## Requirements
- R1: After reset the three masks are 1 (all restart lines masked), the global enable is 0, both edge latches are clear, `sod_out` is 0, `irq_out` and `inta_out` are 0, and the state is IDLE.
- R2: A rising edge on `trap_in` sets the trap latch regardless of the masks and the global enable. The trap has the highest priority and its vector is 0x0024. Accepting the trap clears its latch.
- R3: Priority runs trap > RST7.5 > RST6.5 > RST5.5 > general request. The vectors are 0x003C for 7.5, 0x0034 for 6.5 and 0x002C for 5.5. While in WAIT, `vec_out` follows the current highest eligible source.
- R4: A rising edge on `rst75_in` sets the 7.5 pending latch even while 7.5 is masked. The latch holds until 7.5 is accepted or a mask write has bit 4 = 1. A new edge in the same cycle as the clear wins.
- R5: `rst65_in` and `rst55_in` are level sensitive and are eligible only while high, unmasked and globally enabled.
- R6: In a mask write, bits 2..0 become the masks for 5.5 (bit 0), 6.5 (bit 1) and 7.5 (bit 2), with 1 meaning masked. This happens only when bit 3 is 1; otherwise the masks are unchanged.
- R7: In a mask write with bit 6 = 1, bit 7 is copied to `sod_out`. With bit 6 = 0, `sod_out` keeps its value. Bit 5 has no effect.
- R8: `status_out` reports the masks in bits 2..0 (bit 0 = 5.5), the global enable in bit 3, the 5.5 level in bit 4, the 6.5 level in bit 5, the 7.5 pending latch in bit 6 and `sid_in` in bit 7.
- R9: `ei_pulse` sets the global enable and `di_pulse` clears it; if both are high in the same cycle, the disable wins. While the enable is 0, only the trap can make a source eligible.
- R10: `irq_out` rises one cycle after a source becomes eligible. It stays high until `core_take` is sampled while a winner exists, or until no source is eligible any longer.
- R11: Acceptance clears the global enable, and an acceptance clear outweighs a simultaneous `ei_pulse`. In the cycle after acceptance, `inta_out` is high for exactly one cycle if the general request won, and stays low otherwise.
- R12: The general request is non-vectored: while it is the winner, `vec_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_in | input | 1 | Non-maskable trap, rising-edge latched |
| rst75_in | input | 1 | Restart 7.5, rising-edge latched |
| rst65_in | input | 1 | Restart 6.5, level |
| rst55_in | input | 1 | Restart 5.5, level |
| intr_in | input | 1 | General non-vectored request, level |
| ei_pulse | input | 1 | Set global enable |
| di_pulse | input | 1 | Clear global enable |
| mask_wr | input | 1 | Mask-write strobe |
| mask_data | input | 8 | Mask-write byte |
| sid_in | input | 1 | Serial input bit, shown in status |
| core_take | input | 1 | Core accepts the presented request |
| irq_out | output | 1 | Request to the core |
| vec_out | output | 16 | Vector address of the winner (0 for the general request) |
| inta_out | output | 1 | Acknowledge strobe for the general request |
| status_out | output | 8 | Status byte |
| sod_out | output | 1 | Serial output bit |

## Verification
The bench targets a trap that arrives while the global enable is off, and a 7.5 edge that is caught while its mask is set. A design that gated either latch with the mask or the enable would lose the event. It also targets a clear of the 7.5 latch and a new edge in the same cycle, and an enable and a disable pulse in the same cycle; getting the precedence wrong in either case leaves a stale or a missing interrupt. A level source that is dropped during WAIT must send the machine back to IDLE, not leave a request with no owner. The bench also checks that only the general request produces the acknowledge strobe and a zero vector, and that a mask write without its qualifier bits leaves the masks and the serial output unchanged.

// File: rtl/vintc_pkg.sv
package vintc_pkg;
    localparam int VEC_W     = 16;
    localparam int STAT_W    = 8;
    localparam int NUM_SRC   = 5;
    localparam int NUM_MASK  = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAIT  = 2'd1,
        ST_GRANT = 2'd2
    } vintc_state_t;

    // Order of the enum is the priority order after NONE
    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_TRAP = 3'd1,
        SRC_R75  = 3'd2,
        SRC_R65  = 3'd3,
        SRC_R55  = 3'd4,
        SRC_INTR = 3'd5
    } vintc_src_t;
endpackage

// File: rtl/vintc_edge_latch.sv
module vintc_edge_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    input  logic clr,
    output logic q
);
    logic prev;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= 1'b0;
            q    <= 1'b0;
        end else begin
            prev <= sig_in;
            // a fresh edge outweighs a clear in the same cycle
            q    <= (q & ~clr) | (sig_in & ~prev);
        end
    end
endmodule

// File: rtl/vintc_ctrl_regs.sv
module vintc_ctrl_regs #(
    parameter int NMASK = 3,
    parameter int DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [DW-1:0]    data,
    input  logic             ei,
    input  logic             di,
    input  logic             accept,
    output logic [NMASK-1:0] mask,
    output logic             ie,
    output logic             sod,
    output logic             clr_r75
);
    localparam int MSE_BIT = NMASK;
    localparam int CLR_BIT = NMASK + 1;
    localparam int SOE_BIT = DW - 2;
    localparam int SOD_BIT = DW - 1;

    assign clr_r75 = wr & data[CLR_BIT];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '1;
            ie   <= 1'b0;
            sod  <= 1'b0;
        end else begin
            if (wr && data[MSE_BIT]) mask <= data[NMASK-1:0];
            if (wr && data[SOE_BIT]) sod  <= data[SOD_BIT];
            ie <= (ie | ei) & ~di & ~accept;
        end
    end
endmodule

// File: rtl/vintc_arbiter.sv
module vintc_arbiter
    import vintc_pkg::*;
#(
    parameter int NSRC = 5
) (
    input  logic [NSRC-1:0] req,     // index 0 = highest priority
    output vintc_src_t      winner,
    output logic            any
);
    always_comb begin
        winner = SRC_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) winner = vintc_src_t'(i + 1);
        end
        any = |req;
    end
endmodule

// File: rtl/vintc_top.sv
module vintc_top
    import vintc_pkg::*;
#(
    parameter logic [VEC_W-1:0] VEC_BASE = 16'h0024,
    parameter int               VEC_STEP = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_in,
    input  logic              rst75_in,
    input  logic              rst65_in,
    input  logic              rst55_in,
    input  logic              intr_in,
    input  logic              ei_pulse,
    input  logic              di_pulse,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_data,
    input  logic              sid_in,
    input  logic              core_take,
    output logic              irq_out,
    output logic [VEC_W-1:0]  vec_out,
    output logic              inta_out,
    output logic [STAT_W-1:0] status_out,
    output logic              sod_out
);
    localparam logic [VEC_W-1:0] V55 = VEC_BASE + VEC_W'(VEC_STEP);
    localparam logic [VEC_W-1:0] V65 = VEC_BASE + VEC_W'(2 * VEC_STEP);
    localparam logic [VEC_W-1:0] V75 = VEC_BASE + VEC_W'(3 * VEC_STEP);

    vintc_state_t         state, nxt;
    vintc_src_t           winner, grant_src;
    logic                 any, accept;
    logic                 trap_lat, p75, ie, sod, clr_wr75;
    logic [NUM_MASK-1:0]  mask;
    logic [NUM_SRC-1:0]   req;

    assign accept = (state == ST_WAIT) & any & core_take;

    vintc_edge_latch u_trap (
        .clk(clk), .rst_n(rst_n), .sig_in(trap_in),
        .clr(accept & (winner == SRC_TRAP)), .q(trap_lat)
    );

    vintc_edge_latch u_r75 (
        .clk(clk), .rst_n(rst_n), .sig_in(rst75_in),
        .clr(clr_wr75 | (accept & (winner == SRC_R75))), .q(p75)
    );

    vintc_ctrl_regs #(.NMASK(NUM_MASK), .DW(STAT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(mask_wr), .data(mask_data),
        .ei(ei_pulse), .di(di_pulse), .accept(accept),
        .mask(mask), .ie(ie), .sod(sod), .clr_r75(clr_wr75)
    );

    assign req = {ie & intr_in,
                  ie & ~mask[0] & rst55_in,
                  ie & ~mask[1] & rst65_in,
                  ie & ~mask[2] & p75,
                  trap_lat};

    vintc_arbiter #(.NSRC(NUM_SRC)) u_arb (
        .req(req), .winner(winner), .any(any)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            grant_src <= SRC_NONE;
        end else begin
            state <= nxt;
            if (accept) grant_src <= winner;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = any ? ST_WAIT : ST_IDLE;
            ST_WAIT:  nxt = !any ? ST_IDLE : (core_take ? ST_GRANT : ST_WAIT);
            ST_GRANT: nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        irq_out  = 1'b0;
        vec_out  = '0;
        inta_out = 1'b0;
        unique case (state)
            ST_WAIT: begin
                irq_out = 1'b1;
                case (winner)
                    SRC_TRAP: vec_out = VEC_BASE;
                    SRC_R75:  vec_out = V75;
                    SRC_R65:  vec_out = V65;
                    SRC_R55:  vec_out = V55;
                    default:  vec_out = '0;
                endcase
            end
            ST_GRANT: inta_out = (grant_src == SRC_INTR);
            default: ;
        endcase
    end

    assign status_out = {sid_in, p75, rst65_in, rst55_in, ie, mask};
    assign sod_out    = sod;
endmodule

// File: rtl/vintc_chk.sv
module vintc_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rst75_in,
    input logic       di_pulse,
    input logic       mask_wr,
    input logic [7:0] mask_data,
    input logic       core_take,
    input logic       irq_out,
    input logic       inta_out,
    input logic [7:0] status_out,
    input logic       sod_out
);
    // R4
    r75_caught_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst75_in) |=> status_out[6]);
    // R6
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && !mask_data[3]) |=> $stable(status_out[2:0]));
    // R7
    sod_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_data[6]) |=> (sod_out == $past(mask_data[7])));
    // R9
    di_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        di_pulse |=> !status_out[3]);
    // R11
    ack_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta_out |-> $past(irq_out && core_take));
    // R11
    ack_ie_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inta_out |-> !status_out[3]);
endmodule

bind vintc_top vintc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .rst75_in(rst75_in), .di_pulse(di_pulse),
    .mask_wr(mask_wr), .mask_data(mask_data), .core_take(core_take),
    .irq_out(irq_out), .inta_out(inta_out), .status_out(status_out),
    .sod_out(sod_out)
);

// File: tb/sim_vintc_top.sv
module sim_vintc_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trap_in = 0, rst75_in = 0, rst65_in = 0, rst55_in = 0, intr_in = 0;
    logic ei_pulse = 0, di_pulse = 0, mask_wr = 0, sid_in = 0, core_take = 0;
    logic [7:0]  mask_data = 0;
    logic        irq_out, inta_out, sod_out;
    logic [15:0] vec_out;
    logic [7:0]  status_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    vintc_top u0 (
        .clk(clk), .rst_n(rst_n), .trap_in(trap_in), .rst75_in(rst75_in),
        .rst65_in(rst65_in), .rst55_in(rst55_in), .intr_in(intr_in),
        .ei_pulse(ei_pulse), .di_pulse(di_pulse), .mask_wr(mask_wr),
        .mask_data(mask_data), .sid_in(sid_in), .core_take(core_take),
        .irq_out(irq_out), .vec_out(vec_out), .inta_out(inta_out),
        .status_out(status_out), .sod_out(sod_out)
    );

    // ---------------- reference model ----------------
    int   m_st, m_src;
    bit   m_trap, m_p75, m_ie, m_sod, m_ptrap, m_p75prev;
    bit [2:0] m_msk;

    function automatic int m_win();
        if (m_trap) return 1;
        if (m_ie && m_p75 && !m_msk[2]) return 2;
        if (m_ie && rst65_in && !m_msk[1]) return 3;
        if (m_ie && rst55_in && !m_msk[0]) return 4;
        if (m_ie && intr_in) return 5;
        return 0;
    endfunction

    function automatic logic [15:0] m_vec(int w);
        case (w)
            1: return 16'h0024;
            2: return 16'h003C;
            3: return 16'h0034;
            4: return 16'h002C;
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_src = 0; m_trap = 0; m_p75 = 0; m_ie = 0; m_sod = 0;
            m_ptrap = 0; m_p75prev = 0; m_msk = 3'b111;
        end else begin
            int  w;
            bit  acc, t_n, p_n, ie_n;
            w    = m_win();
            acc  = (m_st == 1) && (w != 0) && core_take;
            t_n  = (m_trap && !(acc && w == 1)) || (trap_in && !m_ptrap);
            p_n  = (m_p75 && !(acc && w == 2) && !(mask_wr && mask_data[4]))
                   || (rst75_in && !m_p75prev);
            ie_n = (m_ie || ei_pulse) && !di_pulse && !acc;
            if (mask_wr && mask_data[3]) m_msk = mask_data[2:0];
            if (mask_wr && mask_data[6]) m_sod = mask_data[7];
            case (m_st)
                0: m_st = (w != 0) ? 1 : 0;
                1: m_st = (w == 0) ? 0 : (core_take ? 2 : 1);
                default: m_st = 0;
            endcase
            if (acc) m_src = w;
            m_trap = t_n; m_p75 = p_n; m_ie = ie_n;
            m_ptrap = trap_in; m_p75prev = rst75_in;
        end
    end

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        logic [7:0] st_e;
        int w;
        if (!rst_n) return;
        w    = m_win();
        st_e = {sid_in, m_p75, rst65_in, rst55_in, m_ie, m_msk};
        chk(irq_out, m_st == 1, "R10 irq");
        chk(vec_out, (m_st == 1) ? m_vec(w) : 16'h0, "R3 vector");
        chk(inta_out, (m_st == 2) && (m_src == 5), "R11 ack");
        chk(status_out, st_e, "R8 status");
        chk(sod_out, m_sod, "R7 sod");
    endtask

    task automatic tick();
        @(negedge clk);
        compare();
    endtask

    task automatic wr_mask(input logic [7:0] d);
        mask_wr = 1; mask_data = d;
        tick();
        mask_wr = 0; mask_data = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        sid_in = 1;
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk(status_out, 8'h87, "R1 reset status");
        chk(irq_out, 0, "R1 reset irq");
        chk(sod_out, 0, "R1 reset sod");

        wr_mask(8'h00); tick();
        chk(status_out[2:0], 3'b111, "R6 no qualifier");
        wr_mask(8'h08); tick();
        chk(status_out[2:0], 3'b000, "R6 unmask");

        ei_pulse = 1; tick(); ei_pulse = 0; tick();
        chk(status_out[3], 1, "R9 enable set");

        rst55_in = 1; tick(); tick();
        chk(irq_out, 1, "R5 level request");
        chk(vec_out, 16'h002C, "R5 vector");
        rst65_in = 1; tick(); tick();
        chk(vec_out, 16'h0034, "R3 6.5 above 5.5");

        core_take = 1; tick(); core_take = 0;
        chk(inta_out, 0, "R11 no ack for vectored");
        chk(status_out[3], 0, "R11 enable cleared");
        tick(); tick();
        chk(irq_out, 0, "R9 gated when disabled");

        trap_in = 1; tick(); tick();
        chk(irq_out, 1, "R2 trap while disabled");
        chk(vec_out, 16'h0024, "R2 trap vector");
        core_take = 1; tick(); core_take = 0; tick(); tick();
        chk(irq_out, 0, "R2 trap latch cleared");
        trap_in = 0; rst55_in = 0; rst65_in = 0;

        wr_mask(8'h0C);
        ei_pulse = 1; tick(); ei_pulse = 0;
        rst75_in = 1; tick(); rst75_in = 0; tick();
        chk(status_out[6], 1, "R4 pending while masked");
        chk(irq_out, 0, "R4 masked no request");
        wr_mask(8'h08); tick();
        chk(vec_out, 16'h003C, "R4 vector after unmask");
        wr_mask(8'h18); tick();
        chk(status_out[6], 0, "R4 cleared by write");

        intr_in = 1; tick(); tick();
        chk(irq_out, 1, "R12 general request");
        chk(vec_out, 16'h0000, "R12 non-vectored");
        core_take = 1; tick(); core_take = 0; intr_in = 0;
        chk(inta_out, 1, "R11 ack strobe");
        tick();
        chk(inta_out, 0, "R11 ack one cycle");

        wr_mask(8'hC0); chk(sod_out, 1, "R7 sod set");
        wr_mask(8'h80); chk(sod_out, 1, "R7 no enable keeps");
        wr_mask(8'h60); chk(sod_out, 0, "R7 sod cleared");

        ei_pulse = 1; di_pulse = 1; tick(); ei_pulse = 0; di_pulse = 0; tick();
        chk(status_out[3], 0, "R9 disable wins");

        ei_pulse = 1; tick(); ei_pulse = 0;
        rst55_in = 1; tick(); tick();
        chk(irq_out, 1, "R10 request up");
        rst55_in = 0; tick(); tick();
        chk(irq_out, 0, "R10 withdrawn to idle");

        for (int i = 0; i < 4000; i++) begin
            trap_in   = ($urandom_range(0, 15) == 0);
            rst75_in  = ($urandom_range(0, 7) == 0);
            rst65_in  = ($urandom_range(0, 3) == 0);
            rst55_in  = ($urandom_range(0, 2) == 0);
            intr_in   = ($urandom_range(0, 2) == 0);
            ei_pulse  = ($urandom_range(0, 3) == 0);
            di_pulse  = ($urandom_range(0, 9) == 0);
            mask_wr   = ($urandom_range(0, 7) == 0);
            mask_data = 8'($urandom);
            sid_in    = 1'($urandom);
            core_take = ($urandom_range(0, 2) == 0);
            tick();
        end
        finish_run();
    end
endmodule